// File: doc/BRIEF.md
# Bipolar Inductive-Sensor Period Counter

This block runs the digital side of a three-axis magneto-inductive field measurement. A host hands it a decoded 8-bit command. The command picks one sensor axis and one oscillator divide ratio. The block then biases that axis forward and times a fixed number of oscillator periods in reference clock cycles. Next it reverses the bias and times the same number of periods again. It reports forward minus reverse as a saturated signed 16-bit value and raises a ready flag. Because the result is a difference of the two counts, zero field gives a result near zero, and the sign of the result gives the field direction.

The oscillator of each axis reaches the block as a digital square wave. Each wave is synchronized and edge-detected before it is counted. Axis code 00 selects a scaling mode instead of a measurement: the block counts reference cycles until a later command ends the count. Two test modes are available. The oscillator test keeps one axis oscillating in a chosen direction and routes its wave to a test output. The clock test toggles a test pin on every clock.

A stalled oscillator is caught by a per-direction timeout. Once a result is ready, releasing the host select puts the block into a low-power indication. A synchronous reset returns the block to idle and must come before each new command.

Top module: `mi_period_meter`

## Requirements
- R1: A command is a byte whose fields are: bit 7 clock-test enable, bits 6..4 period select, bit 3 direction, bit 2 oscillator-test enable, bits 1..0 axis. A command is accepted only in the idle state that follows reset. Apart from the mode exits in R7 and R8, a command presented while a measurement is running or a result is ready has no effect.
- R2: Axis code 01 drives bit 0 of the drive outputs, code 10 drives bit 1 and code 11 drives bit 2. At most one bit across `driveFwd` and `driveRev` together is high at any time.
- R3: Period select value p sets the number of oscillator periods timed in each direction to 32·2^p, for p from 0 (32 periods) to 7 (4096 periods).
- R4: A measurement first asserts `driveFwd` for the selected axis, then `driveRev`. Each direction counts the reference cycles from one synchronized rising edge of the oscillator to the edge that completes the period count. The result is the forward count minus the reverse count.
- R5: When the reverse count completes, `ready` rises and the drives fall. After that, `ready` and `result` hold until reset, and further commands are ignored.
- R6: A difference above 32767 is reported as 32767 (0x7FFF). A difference below -32768 is reported as -32768 (0x8000).
- R7: Axis code 00 selects scaling mode, in which no drive is asserted and the block counts reference cycles from the accepting edge. A later command with a non-zero axis code ends the count. The result is then the number of clock edges from the accepting edge to the ending edge, and `ready` rises.
- R8: A command with the oscillator-test bit set and a non-zero axis keeps that axis driven: forward when the direction bit is 0, reverse when it is 1. In this mode `compOut` follows that axis's oscillator two clocks late. A later command with the oscillator-test bit clear ends the mode, drops the drive and returns the block to idle. With axis code 00, R7 applies instead.
- R9: When the oscillator-test bit is 0, the direction bit has no effect, and the measurement still runs forward first.
- R10: While the latched command has bit 7 set, `hsTestOut` inverts on every clock, starting on the clock after acceptance. Otherwise `hsTestOut` is 1.
- R11: A synchronous reset clears the latched command, `result`, `ready`, `stalled`, both drive buses and `compOut`, and sets `hsTestOut` to 1.
- R12: If a direction has not completed TMO_CYC cycles after it started, the block sets `stalled` and drops the drives. `ready` stays low until the next reset.
- R13: `lowPower` is high exactly when `ready` is high and `hostSel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the counted clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | One-cycle strobe qualifying `cmdByte` |
| cmdByte | input | 8 | Decoded command byte |
| hostSel | input | 1 | High while the host keeps the block selected |
| oscIn | input | 3 | Oscillator square waves, bit 0 X, bit 1 Y, bit 2 Z |
| driveFwd | output | 3 | Forward bias enables, one per axis |
| driveRev | output | 3 | Reverse bias enables, one per axis |
| result | output | 16 | Signed two's complement result |
| ready | output | 1 | Result is valid |
| lowPower | output | 1 | Result ready and host deselected |
| stalled | output | 1 | Measurement aborted by timeout |
| compOut | output | 1 | Oscillator test output |
| hsTestOut | output | 1 | Clock test output |

## Verification
Each check samples on the falling edge, in the cycle the registers put the answer there. `ready` and `result` appear on the falling edge after the clock that sees the final synchronized edge. The scaling result equals the exact number of clock edges between the two command strobes. `compOut` lags the oscillator by exactly two rising edges. `stalled` rises exactly TMO_CYC cycles after acceptance. The bench's oscillators produce one rising edge every fixed number of clocks, so each period count, and each expected result, is a product that can be computed exactly.

// File: rtl/mipc_pkg.sv
package mipc_pkg;
  localparam int NUM_AXES = 3;
  localparam int PS_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FWD, ST_REV, ST_SCALE, ST_OSCTEST, ST_DONE, ST_ABORT
  } meas_state_t;

  typedef struct packed {
    logic hsTest;
    logic [PS_W-1:0] period;
    logic dir;
    logic oscTest;
    logic [1:0] axis;
  } cmd_t;

  typedef struct packed {
    logic clear;
    logic measure;
    logic isRev;
    logic scale;
    logic latchScale;
  } dp_strobe_t;
endpackage

// File: rtl/mipc_sync.sv
module mipc_sync (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic level,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign rise = s2 & ~s3;
endmodule

// File: rtl/mipc_datapath.sv
module mipc_datapath
  import mipc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int TMO_CYC = 50000,
  parameter int MIN_DIV_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_AXES-1:0] oscIn,
  input  logic [1:0] axisSel,
  input  logic [PS_W-1:0] periodSel,
  input  dp_strobe_t strobe,
  output logic dirDone,
  output logic dirTimeout,
  output logic [NUM_AXES-1:0] oscLevel,
  output logic [15:0] result
);
  localparam int EDGE_W = MIN_DIV_LOG2 + (1 << PS_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYC - 1);
  localparam logic signed [CNT_W:0] SAT_HI = (CNT_W+1)'(32767);
  localparam logic signed [CNT_W:0] SAT_LO = -(CNT_W+1)'(32768);

  logic [NUM_AXES-1:0] rise;
  logic selEdge;
  logic armed;
  logic [CNT_W-1:0] refCnt, refNext, tmoCnt, fwdCnt;
  logic [EDGE_W-1:0] edgesLeft, periodLen;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_sync
    mipc_sync u_sync (
      .clk(clk), .rst(rst), .d(oscIn[a]), .level(oscLevel[a]), .rise(rise[a])
    );
  end

  always_comb begin
    selEdge = 1'b0;
    for (int i = 0; i < NUM_AXES; i++)
      if (axisSel == 2'(i + 1)) selEdge = rise[i];
  end

  assign periodLen = EDGE_W'(1) << (MIN_DIV_LOG2 + int'(periodSel));
  assign refNext = (refCnt == CNT_MAX) ? refCnt : refCnt + 1'b1;
  assign dirDone = strobe.measure && armed && selEdge && (edgesLeft == EDGE_W'(1));
  assign dirTimeout = strobe.measure && (tmoCnt == TMO_LAST);

  function automatic logic [15:0] satTo16(input logic signed [CNT_W:0] v);
    if (v > SAT_HI) return 16'h7fff;
    else if (v < SAT_LO) return 16'h8000;
    else return v[15:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      refCnt <= '0;
      tmoCnt <= '0;
      edgesLeft <= '0;
    end else if (strobe.clear) begin
      armed <= 1'b0;
      refCnt <= '0;
      tmoCnt <= '0;
      edgesLeft <= periodLen;
    end else if (strobe.measure) begin
      if (tmoCnt != CNT_MAX) tmoCnt <= tmoCnt + 1'b1;
      if (!armed) begin
        if (selEdge) begin
          armed <= 1'b1;
          refCnt <= '0;
        end
      end else begin
        refCnt <= refNext;
        if (selEdge) edgesLeft <= edgesLeft - 1'b1;
      end
    end else if (strobe.scale) begin
      refCnt <= refNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwdCnt <= '0;
      result <= '0;
    end else begin
      if (dirDone && !strobe.isRev) fwdCnt <= refNext;
      if (dirDone && strobe.isRev)
        result <= satTo16($signed({1'b0, fwdCnt}) - $signed({1'b0, refNext}));
      if (strobe.latchScale) result <= satTo16($signed({1'b0, refNext}));
    end
  end

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (rst)
    strobe.measure |-> (tmoCnt <= TMO_LAST)); // R12
endmodule

// File: rtl/mipc_control.sv
module mipc_control
  import mipc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cmdValid,
  input  logic [7:0] cmdByte,
  input  logic hostSel,
  input  logic dirDone,
  input  logic dirTimeout,
  input  logic [NUM_AXES-1:0] oscLevel,
  output dp_strobe_t strobe,
  output logic [1:0] axisSel,
  output logic [PS_W-1:0] periodSel,
  output logic [NUM_AXES-1:0] driveFwd,
  output logic [NUM_AXES-1:0] driveRev,
  output logic compOut,
  output logic hsTestOut,
  output logic ready,
  output logic lowPower,
  output logic stalled
);
  meas_state_t state, stateNext;
  cmd_t cmdIn, cmdQ;
  logic accept, leaveTest, endScale, hsT, hsEn;
  logic [NUM_AXES-1:0] axisOh;

  assign cmdIn = cmd_t'(cmdByte);
  assign accept = (state == ST_IDLE) && cmdValid;
  assign leaveTest = (state == ST_OSCTEST) && cmdValid && !cmdIn.oscTest;
  assign endScale = (state == ST_SCALE) && cmdValid && (cmdIn.axis != 2'd0);
  assign hsEn = cmdQ.hsTest;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:
        if (accept) begin
          if (cmdIn.axis == 2'd0) stateNext = ST_SCALE;
          else if (cmdIn.oscTest) stateNext = ST_OSCTEST;
          else stateNext = ST_FWD;
        end
      ST_FWD:
        if (dirDone) stateNext = ST_REV;
        else if (dirTimeout) stateNext = ST_ABORT;
      ST_REV:
        if (dirDone) stateNext = ST_DONE;
        else if (dirTimeout) stateNext = ST_ABORT;
      ST_SCALE:   if (endScale) stateNext = ST_DONE;
      ST_OSCTEST: if (leaveTest) stateNext = ST_IDLE;
      default:    stateNext = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cmdQ <= '0;
      hsT <= 1'b1;
    end else begin
      state <= stateNext;
      if (accept || leaveTest) cmdQ <= cmdIn;
      hsT <= hsEn ? ~hsT : 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    strobe.clear = accept || ((state == ST_FWD) && dirDone);
    strobe.measure = (state == ST_FWD) || (state == ST_REV);
    strobe.isRev = (state == ST_REV);
    strobe.scale = (state == ST_SCALE);
    strobe.latchScale = endScale;
  end

  assign axisSel = cmdQ.axis;
  assign periodSel = (state == ST_IDLE) ? cmdIn.period : cmdQ.period;
  assign axisOh = (cmdQ.axis == 2'd0) ? '0 : NUM_AXES'(1) << (cmdQ.axis - 2'd1);

  always_comb begin
    driveFwd = '0;
    driveRev = '0;
    case (state)
      ST_FWD: driveFwd = axisOh;
      ST_REV: driveRev = axisOh;
      ST_OSCTEST:
        if (cmdQ.dir) driveRev = axisOh;
        else driveFwd = axisOh;
      default: ;
    endcase
  end

  assign compOut = (state == ST_OSCTEST) && |(oscLevel & axisOh);
  assign hsTestOut = hsT;
  assign ready = (state == ST_DONE);
  assign lowPower = ready && !hostSel;
  assign stalled = (state == ST_ABORT);

  AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({driveFwd, driveRev})); // R2
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R5
  AST_HS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    ($past(hsEn) && hsEn) |-> (hsT != $past(hsT))); // R10
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ready && !stalled && driveFwd == '0 && driveRev == '0)); // R11
endmodule

// File: rtl/mi_period_meter.sv
module mi_period_meter
  import mipc_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int TMO_CYC = 50000,
  parameter int MIN_DIV_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic cmdValid,
  input  logic [7:0] cmdByte,
  input  logic hostSel,
  input  logic [2:0] oscIn,
  output logic [2:0] driveFwd,
  output logic [2:0] driveRev,
  output logic [15:0] result,
  output logic ready,
  output logic lowPower,
  output logic stalled,
  output logic compOut,
  output logic hsTestOut
);
  dp_strobe_t strobe;
  logic dirDone, dirTimeout;
  logic [1:0] axisSel;
  logic [PS_W-1:0] periodSel;
  logic [NUM_AXES-1:0] oscLevel;

  mipc_control u_ctrl (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .hostSel(hostSel), .dirDone(dirDone), .dirTimeout(dirTimeout),
    .oscLevel(oscLevel), .strobe(strobe), .axisSel(axisSel),
    .periodSel(periodSel), .driveFwd(driveFwd), .driveRev(driveRev),
    .compOut(compOut), .hsTestOut(hsTestOut), .ready(ready),
    .lowPower(lowPower), .stalled(stalled)
  );

  mipc_datapath #(
    .CNT_W(CNT_W), .TMO_CYC(TMO_CYC), .MIN_DIV_LOG2(MIN_DIV_LOG2)
  ) u_dp (
    .clk(clk), .rst(rst), .oscIn(oscIn), .axisSel(axisSel),
    .periodSel(periodSel), .strobe(strobe), .dirDone(dirDone),
    .dirTimeout(dirTimeout), .oscLevel(oscLevel), .result(result)
  );

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(result)); // R5
endmodule

// File: tb/sim_mi_period_meter.sv
module sim_mi_period_meter;
  localparam int TMO = 40000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic hostSel = 1'b1;
  logic [2:0] oscVec;
  logic [2:0] driveFwd, driveRev;
  logic [15:0] result;
  logic ready, lowPower, stalled, compOut, hsTestOut;

  int pf = 10;
  int pr = 10;
  bit stall = 1'b0;
  int nChecks = 0;
  int nFail = 0;
  logic [2:0] h1 = '0, h2 = '0;

  always #10 clk = ~clk;

  mi_period_meter #(.TMO_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdByte(cmdByte),
    .hostSel(hostSel), .oscIn(oscVec), .driveFwd(driveFwd),
    .driveRev(driveRev), .result(result), .ready(ready),
    .lowPower(lowPower), .stalled(stalled), .compOut(compOut),
    .hsTestOut(hsTestOut)
  );

  for (genvar a = 0; a < 3; a++) begin : g_osc
    int ctr = 0;
    int per;
    logic [1:0] lastMode = 2'b00;
    logic oscBit = 1'b0;
    assign per = driveFwd[a] ? pf : pr;
    always @(posedge clk) begin
      lastMode <= {driveFwd[a], driveRev[a]};
      if (stall || {driveFwd[a], driveRev[a]} == 2'b00 ||
          {driveFwd[a], driveRev[a]} != lastMode) begin
        ctr <= 0;
        oscBit <= 1'b0;
      end else begin
        ctr <= (ctr + 1 >= per) ? 0 : ctr + 1;
        oscBit <= (ctr >= per / 2);
      end
    end
    assign oscVec[a] = oscBit;
  end

  always @(posedge clk) begin
    h1 <= oscVec;
    h2 <= h1;
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    cmdValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic sendCmd(logic [7:0] c);
    cmdByte = c;
    cmdValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  // Polls at falling edges; injects one extra command at cycle 20, tracks drive order and axis.
  task automatic runMeas(string req, logic [7:0] c, int f, int r, logic [15:0] exp,
                         logic [2:0] oh, logic [7:0] inject);
    bit seenFwd = 0, orderBad = 0, axisBad = 0;
    int i = 0;
    doReset();
    pf = f;
    pr = r;
    sendCmd(c);
    while (!ready && !stalled && i < 45000) begin
      cmdByte = inject;
      cmdValid = (i == 20);
      @(negedge clk);
      i++;
      if (driveRev != 0 && !seenFwd) orderBad = 1;
      if (driveFwd != 0) seenFwd = 1;
      if (((driveFwd | driveRev) & ~oh) != 0) axisBad = 1;
    end
    cmdValid = 1'b0;
    check(req, "ready", ready, 1);
    check(req, "result", result, exp);
    check("R4", "forward before reverse", {orderBad, seenFwd}, 2'b01);
    check("R2", "only selected axis driven", axisBad, 0);
    check("R5", "drives off when ready", {driveFwd, driveRev}, 0);
  endtask

  task automatic testReset();
    doReset();
    check("R11", "ready after reset", ready, 0);
    check("R11", "result after reset", result, 0);
    check("R11", "drives after reset", {driveFwd, driveRev}, 0);
    check("R11", "stalled/compOut after reset", {stalled, compOut}, 0);
    check("R10", "hsTestOut idle", hsTestOut, 1);
  endtask

  task automatic testReadyHold();
    hostSel = 1'b0;
    #1;
    check("R13", "lowPower deselected", lowPower, 1);
    hostSel = 1'b1;
    #1;
    check("R13", "lowPower selected", lowPower, 0);
    sendCmd(8'h03);
    repeat (3) @(negedge clk);
    check("R5", "command ignored while ready, result", result, 16'd96);
    check("R1", "command ignored while ready, drives", {driveFwd, driveRev, ready}, 7'b0000001);
  endtask

  task automatic testScale();
    doReset();
    sendCmd(8'h00);
    repeat (50) @(negedge clk);
    check("R7", "no drive in scaling", {driveFwd, driveRev}, 0);
    check("R7", "not ready while scaling", ready, 0);
    repeat (49) @(negedge clk);
    sendCmd(8'h01);
    check("R7", "scaling ready", ready, 1);
    check("R7", "scaling count", result, 16'd100);
  endtask

  task automatic testOscTest(logic [7:0] c, logic [2:0] oh, bit rev, int a);
    int bad = 0;
    int highs = 0;
    doReset();
    pf = 8;
    pr = 6;
    sendCmd(c);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (compOut !== h2[a]) bad++;
      if (compOut) highs++;
    end
    check("R8", "test drive", {driveFwd, driveRev}, rev ? {3'b000, oh} : {oh, 3'b000});
    check("R8", "compOut follows oscillator", bad, 0);
    check("R8", "compOut toggles", highs > 5 && highs < 35, 1);
    sendCmd(c & 8'hFB);
    check("R8", "test ended drives", {driveFwd, driveRev, compOut, ready}, 0);
  endtask

  task automatic testHs();
    doReset();
    pf = 4;
    pr = 4;
    sendCmd(8'h81);
    check("R10", "hs first", hsTestOut, 1);
    @(negedge clk);
    check("R10", "hs toggle 1", hsTestOut, 0);
    @(negedge clk);
    check("R10", "hs toggle 2", hsTestOut, 1);
    @(negedge clk);
    check("R10", "hs toggle 3", hsTestOut, 0);
    doReset();
    sendCmd(8'h01);
    repeat (3) @(negedge clk);
    check("R10", "hs held when bit clear", hsTestOut, 1);
  endtask

  task automatic testTimeout();
    int i = 0;
    doReset();
    stall = 1'b1;
    sendCmd(8'h01);
    while (!stalled && i < TMO + 100) begin
      @(negedge clk);
      i++;
    end
    check("R12", "timeout cycle", i, TMO);
    check("R12", "stalled flags", {stalled, ready}, 2'b10);
    check("R12", "drives off", {driveFwd, driveRev}, 0);
    stall = 1'b0;
  endtask

  task automatic testMidReset();
    doReset();
    pf = 10;
    pr = 10;
    sendCmd(8'h81);
    repeat (50) @(negedge clk);
    check("R4", "forward drive mid-run", driveFwd, 3'b001);
    doReset();
    check("R11", "mid-run reset", {driveFwd, driveRev, ready, stalled}, 0);
    check("R11", "mid-run reset hs/result", {hsTestOut, result}, {1'b1, 16'h0});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    testReset();
    // R1 R3 R4: X, 32 periods, 32*(10-7); a Y command mid-run is ignored
    runMeas("R4", 8'h01, 10, 7, 16'd96, 3'b001, 8'h02);
    testReadyHold();
    // R9 R3: Y, 64 periods, direction bit set but test bit clear
    runMeas("R9", 8'h1A, 6, 9, 16'hFF40, 3'b010, 8'h00);
    runMeas("R3", 8'h23, 5, 5, 16'h0000, 3'b100, 8'h00);
    runMeas("R6", 8'h31, 140, 10, 16'h7FFF, 3'b001, 8'h00);
    runMeas("R6", 8'h31, 10, 140, 16'h8000, 3'b001, 8'h00);
    testScale();
    testOscTest(8'h0D, 3'b001, 1'b1, 0);
    testOscTest(8'h06, 3'b010, 1'b0, 1);
    testHs();
    testTimeout();
    testMidReset();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule